// File: doc/BRIEF.md
# Transport-Triggered Function Unit

This block is the execution shell of one function unit in a processor that is programmed by data moves. Moves on the transport bus write two ports: an operand port and a trigger port. A write to the operand port only stores the value. A write to the trigger port starts an operation. The operation takes the operand already held in the unit and the data moved into the trigger port. The operation code travels with the trigger write. Add, subtract, multiply and reverse subtract are provided, and all results wrap modulo 2^DATA_W.

The unit is a two-stage pipeline, and every stage carries its own valid bit. The first stage keeps a private copy of the operand and the trigger data. Because of this copy, the operand port can be rewritten while an earlier operation is still in flight. The second stage is the result register. It holds its value until the next completed operation overwrites it, so software may read it any number of times. A global lock input freezes every stage. While the lock is high, the unit reports that it is not ready. A trigger that arrives while the unit is not ready is discarded and sets a sticky overflow flag.

Top module: `ttfu_unit`

## Requirements
- R1: After reset, res_data is 0, res_ready is 0 and ovf_flag is 0. fu_ready is 1 whenever glock is 0.
- R2: A write to the operand port (opnd_we=1) with trig_we=0 starts no operation: res_ready stays 0 and res_data is unchanged.
- R3: A trigger write accepted on clock edge E loads the result register on the next unlocked edge. res_ready is then 1 for exactly one unlocked cycle.
- R4: The trig_opc encoding is 0 = operand+trigger, 1 = operand-trigger, 2 = low DATA_W bits of operand*trigger, 3 = trigger-operand. All results wrap modulo 2^DATA_W.
- R5: When the operand and the trigger are written on the same edge, the operation uses the operand value held before that edge. The new operand value is stored for later operations.
- R6: A write to the operand port after a trigger does not change the result of that earlier operation.
- R7: Triggers on consecutive unlocked edges each produce a result, on consecutive cycles and in order.
- R8: With no completing operation, res_data holds its value and res_ready stays 0.
- R9: While glock=1, fu_ready is 0 and every pipeline register, the operand register and the result register hold their values. Operand writes made during that time are lost. res_ready keeps its level.
- R10: A trigger write while glock=1 is dropped and produces no result. It sets ovf_flag, and only reset clears ovf_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| glock | input | 1 | Global lock; freezes all stages |
| opnd_we | input | 1 | Operand port write strobe |
| opnd_data | input | DATA_W | Operand port write data |
| trig_we | input | 1 | Trigger port write strobe; starts an operation |
| trig_data | input | DATA_W | Trigger port write data |
| trig_opc | input | 2 | Operation code sent with the trigger |
| fu_ready | output | 1 | Unit can accept a trigger |
| res_ready | output | 1 | Result register holds a newly completed value |
| res_data | output | DATA_W | Result register |
| ovf_flag | output | 1 | Sticky flag: a trigger was dropped |

## Verification
The hardest situation to reach is a lock that arrives while an operation sits between the two stages, with operand writes made during the frozen cycles. The stimulus accepts a trigger and raises glock on the very next cycle. It then writes a new operand three times under the lock and checks that no result appears. After release, the delayed result must appear, and a later trigger must still use the operand stored before the lock. A second lock is raised while the result pulse is high, to show that the pulse is held rather than repeated.

// File: rtl/ttfu_pkg.sv
package ttfu_pkg;

    localparam int OPC_W = 2;

    // Operation selected by the code moved with the trigger
    typedef enum logic [OPC_W-1:0] {
        OPC_ADD  = 2'd0,
        OPC_SUB  = 2'd1,
        OPC_MUL  = 2'd2,
        OPC_RSUB = 2'd3
    } opc_e;

endpackage

// File: rtl/ttfu_lock_ctl.sv
// Decides whether a trigger move is taken or dropped under the global lock.
module ttfu_lock_ctl (
    input  logic glock,
    input  logic trig_we,
    output logic fu_ready,
    output logic accept,
    output logic drop
);

    always_comb begin
        fu_ready = ~glock;
        accept   = trig_we & ~glock;
        drop     = trig_we & glock;
    end

endmodule

// File: rtl/ttfu_alu.sv
// Combinational operation stage between the capture stage and the result register.
module ttfu_alu
    import ttfu_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter bit HAS_MUL = 1'b1
) (
    input  opc_e              opc,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    localparam int PROD_W = 2 * DATA_W;

    logic [DATA_W-1:0] prod_lo;

    generate
        if (HAS_MUL) begin : g_mul
            logic [PROD_W-1:0] prod_full;
            always_comb begin
                prod_full = PROD_W'(a) * PROD_W'(b);
                prod_lo   = prod_full[DATA_W-1:0];
            end
        end else begin : g_nomul
            always_comb prod_lo = '0;
        end
    endgenerate

    always_comb begin
        unique case (opc)
            OPC_ADD:  y = a + b;
            OPC_SUB:  y = a - b;
            OPC_MUL:  y = prod_lo;
            OPC_RSUB: y = b - a;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/ttfu_unit.sv
module ttfu_unit
    import ttfu_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter bit HAS_MUL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glock,
    input  logic              opnd_we,
    input  logic [DATA_W-1:0] opnd_data,
    input  logic              trig_we,
    input  logic [DATA_W-1:0] trig_data,
    input  logic [OPC_W-1:0]  trig_opc,
    output logic              fu_ready,
    output logic              res_ready,
    output logic [DATA_W-1:0] res_data,
    output logic              ovf_flag
);

    typedef struct packed {
        logic [DATA_W-1:0] opnd;   // operand port register
        logic              s1_v;   // capture stage valid
        logic [DATA_W-1:0] s1_a;   // shadow copy of the operand
        logic [DATA_W-1:0] s1_b;   // trigger data
        opc_e              s1_op;
        logic              s2_v;   // result stage valid
        logic [DATA_W-1:0] res;
        logic              ovf;
    } state_t;

    state_t            st_d, st_q;
    logic              accept, drop;
    logic [DATA_W-1:0] alu_y;

    ttfu_lock_ctl u_lock (
        .glock    (glock),
        .trig_we  (trig_we),
        .fu_ready (fu_ready),
        .accept   (accept),
        .drop     (drop)
    );

    ttfu_alu #(
        .DATA_W  (DATA_W),
        .HAS_MUL (HAS_MUL)
    ) u_alu (
        .opc (st_q.s1_op),
        .a   (st_q.s1_a),
        .b   (st_q.s1_b),
        .y   (alu_y)
    );

    always_comb begin
        st_d = st_q;
        if (!glock) begin
            if (opnd_we) begin
                st_d.opnd = opnd_data;
            end
            st_d.s1_v = accept;
            if (accept) begin
                st_d.s1_a  = st_q.opnd;
                st_d.s1_b  = trig_data;
                st_d.s1_op = opc_e'(trig_opc);
            end
            st_d.s2_v = st_q.s1_v;
            if (st_q.s1_v) begin
                st_d.res = alu_y;
            end
        end
        if (drop) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_ready = st_q.s2_v;
    assign res_data  = st_q.res;
    assign ovf_flag  = st_q.ovf;

endmodule

// File: rtl/ttfu_unit_chk.sv
module ttfu_unit_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              glock,
    input logic              trig_we,
    input logic              res_ready,
    input logic [DATA_W-1:0] res_data,
    input logic              ovf_flag
);

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_we && !glock) ##1 !glock |=> res_ready);

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_ready |-> $stable(res_data));

    p_lock_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        glock |=> ($stable(res_data) && $stable(res_ready)));

    p_drop_sets_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_we && glock) |=> ovf_flag);

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

endmodule

bind ttfu_unit ttfu_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glock     (glock),
    .trig_we   (trig_we),
    .res_ready (res_ready),
    .res_data  (res_data),
    .ovf_flag  (ovf_flag)
);

// File: tb/ttfu_unit_tb.sv
module ttfu_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        glock;
    logic        opnd_we;
    logic [15:0] opnd_data;
    logic        trig_we;
    logic [15:0] trig_data;
    logic [1:0]  trig_opc;
    logic        fu_ready;
    logic        res_ready;
    logic [15:0] res_data;
    logic        ovf_flag;

    always #5 clk = ~clk;

    ttfu_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .glock     (glock),
        .opnd_we   (opnd_we),
        .opnd_data (opnd_data),
        .trig_we   (trig_we),
        .trig_data (trig_data),
        .trig_opc  (trig_opc),
        .fu_ready  (fu_ready),
        .res_ready (res_ready),
        .res_data  (res_data),
        .ovf_flag  (ovf_flag)
    );

    typedef struct {
        logic [15:0] val;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] m_opnd = 16'h0;
    bit          edge_locked = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // R4 encoding, computed from the requirement
    function automatic logic [15:0] calc(input logic [1:0] op, input logic [15:0] a,
                                         input logic [15:0] b);
        logic [31:0] p;
        p = 32'(a) * 32'(b);
        case (op)
            2'd0:    return a + b;
            2'd1:    return a - b;
            2'd2:    return p[15:0];
            default: return b - a;
        endcase
    endfunction

    // Driver: called at a falling edge, applies one cycle of moves
    task automatic cyc(input bit owe, input logic [15:0] od, input bit twe,
                       input logic [15:0] td, input logic [1:0] op);
        exp_t it;
        opnd_we   = owe;
        opnd_data = od;
        trig_we   = twe;
        trig_data = td;
        trig_opc  = op;
        @(posedge clk);
        if (!glock) begin
            if (twe) begin
                it.val = calc(op, m_opnd, td);
                it.tag = "R4";
                sb_q.push_back(it);
            end
            if (owe) m_opnd = od;
        end
        @(negedge clk);
        opnd_we = 1'b0;
        trig_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 16'h0, 1'b0, 16'h0, 2'd0);
    endtask

    always @(posedge clk) edge_locked <= glock;

    // Monitor: one pop per newly loaded result
    always @(negedge clk) begin
        if (rst_n && res_ready && !edge_locked) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2", "unexpected result", res_data, 16'h0);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                check(res_data == it.val, it.tag, "scoreboard result", res_data, it.val);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R3 watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; glock = 1'b0; opnd_we = 1'b0; opnd_data = '0;
        trig_we = 1'b0; trig_data = '0; trig_opc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(res_data == 16'h0, "R1", "res_data", res_data, 16'h0);
        check(res_ready == 1'b0, "R1", "res_ready", 16'(res_ready), 16'h0);
        check(ovf_flag == 1'b0, "R1", "ovf_flag", 16'(ovf_flag), 16'h0);
        check(fu_ready == 1'b1, "R1", "fu_ready", 16'(fu_ready), 16'h1);

        // R2 operand write alone
        cyc(1'b1, 16'h0005, 1'b0, 16'h0, 2'd0);
        for (int i = 0; i < 3; i++) begin
            check(res_ready == 1'b0, "R2", "res_ready after operand", 16'(res_ready), 16'h0);
            check(res_data == 16'h0, "R2", "res_data after operand", res_data, 16'h0);
            idle(1);
        end

        // R3 latency and pulse
        cyc(1'b0, 16'h0, 1'b1, 16'h0007, 2'd0);
        check(res_ready == 1'b0, "R3", "res_ready one edge", 16'(res_ready), 16'h0);
        idle(1);
        check(res_ready == 1'b1, "R3", "res_ready two edges", 16'(res_ready), 16'h1);
        check(res_data == 16'h000C, "R3", "res_data", res_data, 16'h000C);
        idle(1);
        check(res_ready == 1'b0, "R3", "pulse end", 16'(res_ready), 16'h0);

        // R4 every code, with wrap
        cyc(1'b1, 16'hFFFF, 1'b0, 16'h0, 2'd0); cyc(1'b0, 16'h0, 1'b1, 16'h0002, 2'd0); idle(2);
        check(res_data == 16'h0001, "R4", "add wrap", res_data, 16'h0001);
        cyc(1'b1, 16'h0003, 1'b0, 16'h0, 2'd0); cyc(1'b0, 16'h0, 1'b1, 16'h0005, 2'd1); idle(2);
        check(res_data == 16'hFFFE, "R4", "sub wrap", res_data, 16'hFFFE);
        cyc(1'b1, 16'h1234, 1'b0, 16'h0, 2'd0); cyc(1'b0, 16'h0, 1'b1, 16'h0100, 2'd2); idle(2);
        check(res_data == 16'h3400, "R4", "mul low", res_data, 16'h3400);
        cyc(1'b1, 16'h0300, 1'b0, 16'h0, 2'd0); cyc(1'b0, 16'h0, 1'b1, 16'h0300, 2'd2); idle(2);
        check(res_data == 16'h0000, "R4", "mul wrap", res_data, 16'h0000);
        cyc(1'b1, 16'h0009, 1'b0, 16'h0, 2'd0); cyc(1'b0, 16'h0, 1'b1, 16'h0004, 2'd3); idle(2);
        check(res_data == 16'hFFFB, "R4", "reverse sub", res_data, 16'hFFFB);

        // R5 operand and trigger on the same edge
        cyc(1'b1, 16'h0010, 1'b1, 16'h0001, 2'd0);
        idle(1);
        check(res_data == 16'h000A, "R5", "uses old operand", res_data, 16'h000A);
        cyc(1'b0, 16'h0, 1'b1, 16'h0001, 2'd0);
        idle(1);
        check(res_data == 16'h0011, "R5", "new operand stored", res_data, 16'h0011);

        // R6 operand rewrite while operation in flight
        cyc(1'b1, 16'd100, 1'b0, 16'h0, 2'd0);
        cyc(1'b0, 16'h0, 1'b1, 16'h0001, 2'd1);
        cyc(1'b1, 16'd200, 1'b0, 16'h0, 2'd0);
        check(res_data == 16'h0063, "R6", "shadow operand", res_data, 16'h0063);
        idle(1);

        // R7 back-to-back triggers
        cyc(1'b1, 16'd10, 1'b0, 16'h0, 2'd0);
        cyc(1'b0, 16'h0, 1'b1, 16'd1, 2'd0);
        check(res_ready == 1'b0, "R7", "first not yet", 16'(res_ready), 16'h0);
        cyc(1'b0, 16'h0, 1'b1, 16'd2, 2'd0);
        check(res_ready && res_data == 16'd11, "R7", "result 1", res_data, 16'd11);
        cyc(1'b0, 16'h0, 1'b1, 16'd3, 2'd0);
        check(res_ready && res_data == 16'd12, "R7", "result 2", res_data, 16'd12);
        cyc(1'b0, 16'h0, 1'b1, 16'd4, 2'd0);
        check(res_ready && res_data == 16'd13, "R7", "result 3", res_data, 16'd13);
        idle(1);
        check(res_ready && res_data == 16'd14, "R7", "result 4", res_data, 16'd14);

        // R8 hold with no activity
        for (int i = 0; i < 3; i++) begin
            idle(1);
            check(!res_ready && res_data == 16'd14, "R8", "result held", res_data, 16'd14);
        end

        // R9 lock with an operation between stages
        cyc(1'b1, 16'd50, 1'b0, 16'h0, 2'd0);
        cyc(1'b0, 16'h0, 1'b1, 16'd8, 2'd1);
        glock = 1'b1;
        #1;
        check(fu_ready == 1'b0, "R9", "fu_ready under lock", 16'(fu_ready), 16'h0);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 16'd999, 1'b0, 16'h0, 2'd0);
            check(!res_ready && res_data == 16'd14, "R9", "frozen pipeline", res_data, 16'd14);
        end
        glock = 1'b0;
        idle(1);
        check(res_ready && res_data == 16'h002A, "R9", "delayed result", res_data, 16'h002A);
        glock = 1'b1;
        idle(2);
        check(res_ready && res_data == 16'h002A, "R9", "pulse held", res_data, 16'h002A);
        glock = 1'b0;
        idle(1);
        check(res_ready == 1'b0, "R9", "pulse ends after lock", 16'(res_ready), 16'h0);
        cyc(1'b0, 16'h0, 1'b1, 16'h0000, 2'd0);
        idle(1);
        check(res_data == 16'd50, "R9", "operand write under lock lost", res_data, 16'd50);
        check(ovf_flag == 1'b0, "R9", "no drop without trigger", 16'(ovf_flag), 16'h0);

        // R10 trigger dropped under lock
        glock = 1'b1;
        cyc(1'b0, 16'h0, 1'b1, 16'h0005, 2'd0);
        check(ovf_flag == 1'b1, "R10", "ovf set", 16'(ovf_flag), 16'h1);
        glock = 1'b0;
        for (int i = 0; i < 3; i++) begin
            idle(1);
            check(ovf_flag && !res_ready, "R10", "sticky, no result", 16'(ovf_flag), 16'h1);
        end

        check(sb_q.size() == 0, "R7", "all results delivered", 16'(sb_q.size()), 16'h0);
        finish_run();
    end

endmodule